// File: doc/BRIEF.md
# Edge-Selectable Wake-Up Interrupt Port

This block watches an eight-pin input port and turns a chosen edge on any pin into an interrupt and wake-up event. Each pin is brought into the clock domain by a two-flop synchronizer. Its edge detector is then armed for either a rising or a falling transition, and a detected trigger is latched into a per-pin pending bit. The pending bits are the only record of the event. No separate port-level pending flag exists: the OR of the enabled pending bits forms the single request, and every pin shares one interrupt vector.

Software sets a per-pin enable mask, a per-pin polarity, a port-level interrupt enable, and clears pending bits by writing ones to them. The request to the CPU is raised only when the port enable and the global enable are both set. While the processor sits in a halt or idle state, any enabled pending pin raises a wake-up, whatever the state of the interrupt enables. A separate output tells the restart logic whether the wake-up should pass through the service routine or resume at the instruction after the halt.

Top module: `wake_irq_port`

## Requirements
- R1: After reset the enable mask, polarity, pending bits and port enable all read 0, so every pin triggers on a rising edge. The outputs irq_req, wake_req and wake_via_isr are low.
- R2: With polarity 0 (rising), a 0-to-1 change on a pin sets its pending bit on the third rising clock edge after the change. The bit is still clear after the second edge.
- R3: Polarity bit 1 selects a falling edge. A pin latches pending only on the edge its polarity bit selects, and the opposite edge leaves the bit unchanged.
- R4: Pending bits latch for pins whose enable bit is 0. Such bits raise neither irq_req nor wake_req.
- R5: irq_req equals port enable AND global_ie AND the OR over pins of (pending AND enable).
- R6: wake_req equals lp_state AND the OR over pins of (pending AND enable), independent of the port enable and global_ie.
- R7: wake_via_isr equals wake_req AND port enable AND global_ie. When it is 0 during a wake-up, execution resumes after the halt.
- R8: Writing to the pending register (cfg_sel 2) clears each pending bit whose write-data bit is 1. Bits written with 0 keep their value.
- R9: If a trigger and a clear for the same pin land in the same cycle, the pending bit ends up set.
- R10: A write that changes a pin's polarity suppresses that pin's edge detection for the following cycle. Changing the polarity while a pin is held at a steady level never sets pending.
- R11: All eight pins feed one request. Any single enabled pending pin raises irq_req, and a pending pin outside the mask does not.
- R12: Register select codes are 0 enable mask, 1 polarity, 2 pending, and 3 control (bit 0 is the port enable). cfg_rdata shows the register selected by cfg_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | Asynchronous port pins |
| lp_state | input | 1 | Processor is in halt or idle |
| global_ie | input | 1 | Global interrupt enable |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for read and write |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected register |
| irq_req | output | 1 | Combined port interrupt request |
| wake_req | output | 1 | Wake-up from low power |
| wake_via_isr | output | 1 | Wake-up should enter the service routine |

## Verification
A pin change takes three clock edges to show up as a pending bit: two synchronizer stages, then the edge-detect history. The bench therefore drives pins on a falling clock edge and reads the pending register one negative edge after the third rising edge. It also reads once after the second rising edge, to show the bit is not early. Register writes, including clears, take effect on the next rising edge. irq_req, wake_req and wake_via_isr follow the registers combinationally, so they are sampled on the same negative edge as the register readback. The edge-wins case places the clear strobe on exactly the third rising edge after the pin change.

// File: rtl/wkport_pkg.sv
package wkport_pkg;

  typedef enum logic [1:0] {
    REG_MASK = 2'd0,
    REG_POL  = 2'd1,
    REG_PEND = 2'd2,
    REG_CTL  = 2'd3
  } reg_sel_e;

  // single-pin edge match: pol 0 rising, pol 1 falling
  function automatic logic edge_match(input logic cur, input logic prv, input logic pol);
    return pol ? (prv & ~cur) : (~prv & cur);
  endfunction

  // next pending value for one pin: a new trigger dominates a clear
  function automatic logic pend_next(input logic cur, input logic clr, input logic hit);
    return (cur & ~clr) | hit;
  endfunction

endpackage

// File: rtl/wk_sync_bank.sv
module wk_sync_bank #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/wk_edge_bank.sv
module wk_edge_bank import wkport_pkg::*; #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] pol_diff,
  output logic [W-1:0] hit
);

  logic [W-1:0] prev_q;
  logic [W-1:0] quiet_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      quiet_q <= '0;
    end else begin
      prev_q  <= lvl;
      quiet_q <= pol_diff;
    end
  end

  for (genvar g = 0; g < W; g++) begin : g_det
    assign hit[g] = edge_match(lvl[g], prev_q[g], pol[g]) & ~quiet_q[g];
  end

endmodule

// File: rtl/wk_pend_bank.sv
module wk_pend_bank import wkport_pkg::*; #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hit,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pend
);

  logic [W-1:0] pend_q;

  for (genvar g = 0; g < W; g++) begin : g_pend
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= pend_next(pend_q[g], clr[g], hit[g]);
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/wk_cfg_regs.sv
module wk_cfg_regs import wkport_pkg::*; #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_wr,
  input  logic [1:0]   cfg_sel,
  input  logic [W-1:0] cfg_wdata,
  input  logic [W-1:0] pend,
  output logic [W-1:0] en,
  output logic [W-1:0] pol,
  output logic         port_ie,
  output logic [W-1:0] clr,
  output logic [W-1:0] pol_diff,
  output logic [W-1:0] rdata
);

  reg_sel_e sel;
  logic [W-1:0] en_q, pol_q;
  logic port_ie_q;

  assign sel = reg_sel_e'(cfg_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      pol_q     <= '0;
      port_ie_q <= 1'b0;
    end else if (cfg_wr) begin
      case (sel)
        REG_MASK: en_q      <= cfg_wdata;
        REG_POL:  pol_q     <= cfg_wdata;
        REG_CTL:  port_ie_q <= cfg_wdata[0];
        default:  ;
      endcase
    end
  end

  assign clr      = (cfg_wr && sel == REG_PEND) ? cfg_wdata : '0;
  assign pol_diff = (cfg_wr && sel == REG_POL) ? (cfg_wdata ^ pol_q) : '0;

  always_comb begin
    case (sel)
      REG_MASK: rdata = en_q;
      REG_POL:  rdata = pol_q;
      REG_PEND: rdata = pend;
      default:  rdata = {{(W-1){1'b0}}, port_ie_q};
    endcase
  end

  assign en      = en_q;
  assign pol     = pol_q;
  assign port_ie = port_ie_q;

endmodule

// File: rtl/wake_irq_port.sv
module wake_irq_port #(
  parameter int N_PINS      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_in,
  input  logic              lp_state,
  input  logic              global_ie,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [N_PINS-1:0] cfg_wdata,
  output logic [N_PINS-1:0] cfg_rdata,
  output logic              irq_req,
  output logic              wake_req,
  output logic              wake_via_isr
);

  logic [N_PINS-1:0] lvl_s;
  logic [N_PINS-1:0] en_q, pol_q, pend_q;
  logic [N_PINS-1:0] hit_w, clr_w, pol_diff_w;
  logic              port_ie_q;
  logic              any_live_w;

  wk_sync_bank #(.W(N_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(lvl_s)
  );

  wk_cfg_regs #(.W(N_PINS)) cfg_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .pend(pend_q), .en(en_q), .pol(pol_q),
    .port_ie(port_ie_q), .clr(clr_w), .pol_diff(pol_diff_w), .rdata(cfg_rdata)
  );

  wk_edge_bank #(.W(N_PINS)) edge_i (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_s), .pol(pol_q),
    .pol_diff(pol_diff_w), .hit(hit_w)
  );

  wk_pend_bank #(.W(N_PINS)) pend_i (
    .clk(clk), .rst_n(rst_n), .hit(hit_w), .clr(clr_w), .pend(pend_q)
  );

  assign any_live_w   = |(pend_q & en_q);
  assign irq_req      = any_live_w & port_ie_q & global_ie;
  assign wake_req     = any_live_w & lp_state;
  assign wake_via_isr = wake_req & port_ie_q & global_ie;

endmodule

// File: rtl/wake_irq_port_chk.sv
module wake_irq_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         lp_state,
  input logic         global_ie,
  input logic         port_ie,
  input logic [W-1:0] en,
  input logic [W-1:0] pend,
  input logic [W-1:0] hit,
  input logic [W-1:0] clr,
  input logic [W-1:0] pol_diff,
  input logic         irq_req,
  input logic         wake_req,
  input logic         wake_via_isr
);

  assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (port_ie && global_ie && (|(pend & en))));

  assert_wake_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (lp_state && (|(pend & en))));

  assert_isr_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_via_isr |-> (wake_req && port_ie && global_ie));

  assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & en) == '0) |-> (!irq_req && !wake_req));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~hit)) |=> ((pend & $past(clr & ~hit)) == '0));

  assert_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((pend & $past(hit)) == $past(hit)));

  assert_pol_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|pol_diff) |=> ((hit & $past(pol_diff)) == '0));

endmodule

bind wake_irq_port wake_irq_port_chk #(.W(N_PINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .lp_state(lp_state), .global_ie(global_ie),
  .port_ie(port_ie_q), .en(en_q), .pend(pend_q), .hit(hit_w), .clr(clr_w),
  .pol_diff(pol_diff_w), .irq_req(irq_req), .wake_req(wake_req),
  .wake_via_isr(wake_via_isr)
);

// File: tb/wake_irq_port_tb_top.sv
module wake_irq_port_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_in = '0;
  logic       lp_state = 1'b0;
  logic       global_ie = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       irq_req, wake_req, wake_via_isr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wake_irq_port dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .lp_state(lp_state),
    .global_ie(global_ie), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_req(irq_req),
    .wake_req(wake_req), .wake_via_isr(wake_via_isr)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    cfg_sel = sel;
    #1 d = cfg_rdata;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;

    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 / R12 reset state of every register
    for (int s = 0; s < 4; s++) begin
      rd(s[1:0], v); chk("R1 reg reset", v, 8'h00);
    end
    chk("R1 outputs", {5'd0, irq_req, wake_req, wake_via_isr}, 8'h00);
    step(1);

    // R12 write/readback
    wr(2'd0, 8'hFF); wr(2'd3, 8'h01); global_ie = 1'b1;
    rd(2'd0, v); chk("R12 mask readback", v, 8'hFF);
    rd(2'd3, v); chk("R12 ctl readback", v, 8'h01);
    step(1);

    // R2 latency: rising edge on pin 3
    pin_in = 8'h08;
    step(2); rd(2'd2, v); chk("R2 not early", v, 8'h00);
    step(1); rd(2'd2, v); chk("R2 third edge", v, 8'h08);
    chk("R5 irq set", {7'd0, irq_req}, 8'h01);
    step(1);
    wr(2'd2, 8'h08);
    rd(2'd2, v); chk("R8 clear", v, 8'h00);
    chk("R5 irq drop", {7'd0, irq_req}, 8'h00);
    pin_in = 8'h00; step(4);
    rd(2'd2, v); chk("R3 falling ignored when rising", v, 8'h00);

    // R3 polarity sweep
    for (int p = 0; p < 4; p++) begin
      wr(2'd1, pats[p]); step(1);
      pin_in = 8'hFF; step(4);
      rd(2'd2, v); chk("R3 rising set", v, ~pats[p]);
      wr(2'd2, 8'hFF);
      pin_in = 8'h00; step(4);
      rd(2'd2, v); chk("R3 falling set", v, pats[p]);
      wr(2'd2, 8'hFF); step(1);
    end

    // R10 polarity flip at steady high level
    wr(2'd1, 8'h00);
    pin_in = 8'hFF; step(4); wr(2'd2, 8'hFF); step(1);
    wr(2'd1, 8'hFF); step(4);
    rd(2'd2, v); chk("R10 flip to falling, high", v, 8'h00);
    wr(2'd1, 8'h00); step(4);
    rd(2'd2, v); chk("R10 flip back, high", v, 8'h00);
    pin_in = 8'h00; step(4);
    wr(2'd2, 8'hFF); step(1);

    // R4 / R6 / R7 masked pins and low-power wake
    wr(2'd0, 8'h0F); lp_state = 1'b1;
    pin_in = 8'h80; step(4);
    rd(2'd2, v); chk("R4 masked pin latches", v, 8'h80);
    chk("R4 masked no irq/wake", {6'd0, irq_req, wake_req}, 8'h00);
    pin_in = 8'h82; step(4);
    rd(2'd2, v); chk("R4 both latched", v, 8'h82);
    chk("R6 wake and irq", {5'd0, irq_req, wake_req, wake_via_isr}, 8'h07);
    wr(2'd3, 8'h00);
    chk("R7 port off: resume after halt", {5'd0, irq_req, wake_req, wake_via_isr}, 8'h02);
    wr(2'd3, 8'h01); global_ie = 1'b0; #1;
    chk("R7 gie off", {5'd0, irq_req, wake_req, wake_via_isr}, 8'h02);
    global_ie = 1'b1; lp_state = 1'b0; #1;
    chk("R6 no low power", {5'd0, irq_req, wake_req, wake_via_isr}, 8'h04);
    step(1);

    // R8 partial clear keeps zero-written bits
    wr(2'd2, 8'h02);
    rd(2'd2, v); chk("R8 partial clear", v, 8'h80);
    wr(2'd2, 8'hFF);
    pin_in = 8'h00; step(4);

    // R9 edge and clear in the same cycle
    wr(2'd0, 8'hFF);
    pin_in = 8'h01; step(4);
    rd(2'd2, v); chk("R9 setup", v, 8'h01);
    pin_in = 8'h00; step(4);
    pin_in = 8'h01; step(2);
    wr(2'd2, 8'h01);
    rd(2'd2, v); chk("R9 edge wins", v, 8'h01);
    wr(2'd2, 8'h01);
    rd(2'd2, v); chk("R9 plain clear", v, 8'h00);
    pin_in = 8'h00; step(4);
    wr(2'd2, 8'hFF); step(1);

    // R11 one request for any pin
    for (int i = 0; i < 8; i++) begin
      pin_in = pin_in | (8'h01 << i); step(4);
      wr(2'd0, 8'h01 << ((i + 1) % 8)); #1;
      chk("R11 unmasked pin idle", {7'd0, irq_req}, (i == 7) ? 8'h01 : 8'h00);
      wr(2'd0, 8'h01 << i); #1;
      chk("R11 single pin request", {7'd0, irq_req}, 8'h01);
      step(1);
    end

    finish_run();
  end

endmodule